// File: doc/BRIEF.md
# Dual-Channel Phase/Frequency Comparator with Lock Detection

This block sits between the two divider chains and the charge-pump current sources of a dual synthesizer. Each channel receives a one-cycle reference pulse and a one-cycle feedback pulse, both synchronous to the reference-oscillator clock. The channel turns their relative timing into three-state pump commands. A source command means the reference side is ahead, and a sink command means the feedback side is ahead. When neither is active the output floats. A per-channel polarity bit swaps the two directions to suit the loop filter and the VCO slope.

Each channel measures its phase error as the number of oscillator clocks between the two edges. Lock is dropped as soon as one comparison shows a large error. Lock is granted again only after a run of consecutive comparisons with a small error. A per-channel run input puts a channel into power save. In power save the channel stops driving, forgets its lock history and counts as locked in the combined flag. When the channel is woken, it asks the external dividers to realign their phases. The channel then keeps its first comparison off the pump, so the loop is not kicked by a stale phase relation.

Top module: `dual_pfd_lock`

## Requirements
- R1: With polarity 1, a reference pulse that is e clocks (e ≥ 1) ahead of the feedback pulse raises up_o (and en_o) for e+1 cycles. The pulse starts in the cycle after the reference pulse is sampled. dn_o stays low. When the feedback pulse leads, dn_o does the same and up_o stays low.
- R2: With polarity 0, the up_o and dn_o roles of R1 are exchanged.
- R3: If both pulses arrive in the same cycle, up_o and dn_o are high together for exactly one cycle. This holds for either polarity.
- R4: en_o is high exactly when up_o or dn_o is high. When en_o is low, the pump output is high-impedance.
- R5: A comparison whose error is 2 clocks or more (UNLOCK_CYC) clears that channel's lock. The clear shows in the cycle after the closing pulse is sampled.
- R6: Lock is set after 3 (CONFIRM) consecutive comparisons with an error of at most 1 clock (LOCK_CYC). A comparison outside that window restarts the run.
- R7: While run_i of a channel is low, its up_o, dn_o and en_o are low from the next cycle on. Its input pulses are ignored. Its lock contribution is high at once.
- R8: lock_o is the AND of the lock contributions of all channels. The contribution of a running channel is its own lock state.
- R9: When run_i rises, resync_o of that channel is high in that same cycle only. The first comparison after the wake-up produces no pump drive and does not count for lock.
- R10: During reset, up_o, dn_o and en_o are low and every channel is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | NUM_CH | Per channel: 1 = normal, 0 = power save |
| pol_i | input | NUM_CH | Per channel pump polarity: 1 = reference-ahead drives up |
| fr_i | input | NUM_CH | Reference-divider pulse, one cycle |
| fp_i | input | NUM_CH | Feedback-divider pulse, one cycle |
| up_o | output | NUM_CH | Pump drive-high command |
| dn_o | output | NUM_CH | Pump drive-low command |
| en_o | output | NUM_CH | Pump output enable (low = high-impedance) |
| resync_o | output | NUM_CH | Divider realignment request on wake-up |
| lock_o | output | 1 | Combined lock flag |

## Verification
The pump commands are registered, so they appear one cycle after the leading pulse is sampled. They stay for error-plus-one cycles and are low again in the cycle after that. The lock change shows one cycle after the closing pulse. resync_o and the combined lock flag follow run_i in the same cycle, because they are combinational from it. The driver computes each expected value together with the cycle in which it is due. The monitor looks at the outputs mid-cycle, after the inputs have settled, and compares only the items due in that cycle. An item that is found past its due cycle counts as a failure.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
    logic en;
  } pump_cmd_t;

  // pol=1: reference-ahead side drives up
  function automatic pump_cmd_t map_pump(logic pol, logic src, logic snk);
    pump_cmd_t c;
    c.up = pol ? src : snk;
    c.dn = pol ? snk : src;
    c.en = src | snk;
    return c;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             gate_i,
  input  logic             fr_i,
  input  logic             fp_i,
  output logic             src_o,
  output logic             snk_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);

  logic fr_lead_q, fp_lead_q, src_q, snk_q;
  logic [ERR_W-1:0] cnt_q;
  logic fr_in, fp_in, start, idle;

  assign fr_in = fr_i & act_i;
  assign fp_in = fp_i & act_i;
  assign idle  = ~fr_lead_q & ~fp_lead_q;
  assign start = (fr_in ^ fp_in) & idle;
  assign done_o = (fr_lead_q & fp_in) | (fp_lead_q & fr_in) | (fr_in & fp_in & idle);
  assign err_o  = idle ? '0 : cnt_q;
  assign src_o  = src_q;
  assign snk_o  = snk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_lead_q <= 1'b0;
      fp_lead_q <= 1'b0;
      cnt_q     <= '0;
      src_q     <= 1'b0;
      snk_q     <= 1'b0;
    end else if (!act_i) begin
      fr_lead_q <= 1'b0;
      fp_lead_q <= 1'b0;
      cnt_q     <= '0;
      src_q     <= 1'b0;
      snk_q     <= 1'b0;
    end else begin
      fr_lead_q <= fr_lead_q ? ~fp_in : (fr_in & ~fp_in & ~fp_lead_q);
      fp_lead_q <= fp_lead_q ? ~fr_in : (fp_in & ~fr_in & ~fr_lead_q);
      if (start)
        cnt_q <= ERR_W'(1);
      else if (!idle && !done_o)
        cnt_q <= (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
      else
        cnt_q <= '0;
      // lagging side stays quiet unless both edges coincide
      src_q <= ~gate_i & (fr_lead_q | (fr_in & ~fp_lead_q));
      snk_q <= ~gate_i & (fp_lead_q | (fp_in & ~fr_lead_q));
    end
  end

  // R3
  both_only_coincident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q && snk_q) |-> $past(fr_i && fp_i));

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int ERR_W      = 8,
  parameter int UNLOCK_CYC = 2,
  parameter int LOCK_CYC   = 1,
  parameter int CONFIRM    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             lock_o
);

  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [ERR_W-1:0] UNL_TH = ERR_W'(UNLOCK_CYC);
  localparam logic [ERR_W-1:0] LK_TH  = ERR_W'(LOCK_CYC);
  localparam logic [CW-1:0]    LAST   = CW'(CONFIRM - 1);

  logic [CW-1:0] good_q;
  logic          lock_q;
  logic          upd;

  assign upd    = en_i & done_i;
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (upd) begin
      if (err_i <= LK_TH) begin
        if (good_q >= LAST) lock_q <= 1'b1;
        else                good_q <= good_q + 1'b1;
      end else begin
        good_q <= '0;
      end
      if (err_i >= UNL_TH) lock_q <= 1'b0;
    end
  end

  // R5
  unlock_on_big_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && err_i >= UNL_TH) |=> !lock_q);

  // R6
  lock_needs_good_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(upd && err_i <= LK_TH));

endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
  import pfd_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int UNLOCK_CYC = 2,
  parameter int LOCK_CYC   = 1,
  parameter int CONFIRM    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pol_i,
  input  logic fr_i,
  input  logic fp_i,
  output logic up_o,
  output logic dn_o,
  output logic en_o,
  output logic resync_o,
  output logic vote_o
);

  logic run_q, blank_q, wake, act, gate;
  logic src, snk, done, lock;
  logic [ERR_W-1:0] err;
  pump_cmd_t cmd;

  assign wake     = run_i & ~run_q;
  assign act      = run_i & ~wake;
  assign gate     = blank_q | wake;
  assign resync_o = wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i)             blank_q <= 1'b0;
      else if (wake)          blank_q <= 1'b1;
      else if (blank_q && done) blank_q <= 1'b0;
    end
  end

  pfd_core #(.ERR_W(ERR_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .gate_i (gate),
    .fr_i   (fr_i),
    .fp_i   (fp_i),
    .src_o  (src),
    .snk_o  (snk),
    .done_o (done),
    .err_o  (err)
  );

  pfd_lock_det #(
    .ERR_W(ERR_W), .UNLOCK_CYC(UNLOCK_CYC), .LOCK_CYC(LOCK_CYC), .CONFIRM(CONFIRM)
  ) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run_i),
    .en_i   (act & ~blank_q),
    .done_i (done),
    .err_i  (err),
    .lock_o (lock)
  );

  assign cmd    = map_pump(pol_i, src, snk);
  assign up_o   = cmd.up;
  assign dn_o   = cmd.dn;
  assign en_o   = cmd.en;
  assign vote_o = lock | ~run_i;

  // R7
  save_floats_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !en_o);

  // R9
  blank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q |-> !en_o);

  // R9
  resync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o);

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int NUM_CH     = 2,
  parameter int ERR_W      = 8,
  parameter int UNLOCK_CYC = 2,
  parameter int LOCK_CYC   = 1,
  parameter int CONFIRM    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] run_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic [NUM_CH-1:0] fr_i,
  input  logic [NUM_CH-1:0] fp_i,
  output logic [NUM_CH-1:0] up_o,
  output logic [NUM_CH-1:0] dn_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] resync_o,
  output logic              lock_o
);

  logic [NUM_CH-1:0] vote;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfd_channel #(
      .ERR_W(ERR_W), .UNLOCK_CYC(UNLOCK_CYC), .LOCK_CYC(LOCK_CYC), .CONFIRM(CONFIRM)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i[c]),
      .pol_i    (pol_i[c]),
      .fr_i     (fr_i[c]),
      .fp_i     (fp_i[c]),
      .up_o     (up_o[c]),
      .dn_o     (dn_o[c]),
      .en_o     (en_o[c]),
      .resync_o (resync_o[c]),
      .vote_o   (vote[c])
    );
  end

  assign lock_o = &vote;

endmodule

// File: tb/dual_pfd_lock_tb.sv
module dual_pfd_lock_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] run = '0, pol = 2'b11, fr = '0, fp = '0;
  logic [1:0] up, dn, en, resync;
  logic       lock;

  always #5 clk = ~clk;

  dual_pfd_lock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .pol_i(pol), .fr_i(fr), .fp_i(fp),
    .up_o(up), .dn_o(dn), .en_o(en), .resync_o(resync), .lock_o(lock)
  );

  typedef struct {
    int    due;
    int    ch;
    int    sig;   // 0 up, 1 dn, 2 en, 3 lock, 4 resync
    bit    exp;
    string req;
  } item_t;

  item_t q[$];
  int    cyc = 0, total = 0, bad = 0;
  bit    lk[2];
  int    good[2];
  bit    blank[2];
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int due, int ch, int sig, bit exp, string req);
    item_t it;
    it.due = due; it.ch = ch; it.sig = sig; it.exp = exp; it.req = req;
    q.push_back(it);
  endfunction

  function automatic bit exp_lock();
    return (lk[0] | ~run[0]) & (lk[1] | ~run[1]);
  endfunction

  function automatic logic get_sig(int ch, int sig);
    case (sig)
      0: return up[ch];
      1: return dn[ch];
      2: return en[ch];
      3: return lock;
      default: return resync[ch];
    endcase
  endfunction

  // monitor: mid-cycle, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          logic act_v;
          act_v = get_sig(q[i].ch, q[i].sig);
          total++;
          if (q[i].due < cyc || act_v !== q[i].exp) begin
            bad++;
            $display("FAIL %s ch%0d sig%0d cyc%0d: actual=%b expected=%b",
                     q[i].req, q[i].ch, q[i].sig, cyc, act_v, q[i].exp);
          end
          q.delete(i);
        end
      end
    end
  end

  // one comparison: lead pulse, lag pulse e clocks later
  task automatic cmp(int ch, bit fr_lead, int e, string req);
    int k;
    bit quiet, p, srcv, snkv, upv, dnv;
    @(negedge clk);
    k = cyc;
    quiet = blank[ch] | ~run[ch];
    p = pol[ch];
    for (int d = 1; d <= e + 2; d++) begin
      bit on;
      on = !quiet && d <= e + 1;
      srcv = on && (e == 0 || fr_lead);
      snkv = on && (e == 0 || !fr_lead);
      upv = p ? srcv : snkv;
      dnv = p ? snkv : srcv;
      push(k + d, ch, 0, upv, req);
      push(k + d, ch, 1, dnv, req);
      push(k + d, ch, 2, upv | dnv, {req, "/R4"});
    end
    if (run[ch]) begin
      if (blank[ch]) blank[ch] = 0;
      else begin
        if (e <= 1) begin
          good[ch]++;
          if (good[ch] >= 3) lk[ch] = 1;
        end else good[ch] = 0;
        if (e >= 2) lk[ch] = 0;
      end
    end
    push(k + e + 1, 0, 3, exp_lock(), {req, "/R6"});
    if (e == 0) begin
      fr[ch] = 1; fp[ch] = 1;
      @(negedge clk);
      fr[ch] = 0; fp[ch] = 0;
    end else begin
      if (fr_lead) fr[ch] = 1; else fp[ch] = 1;
      @(negedge clk);
      fr[ch] = 0; fp[ch] = 0;
      repeat (e - 1) @(negedge clk);
      if (fr_lead) fp[ch] = 1; else fr[ch] = 1;
      @(negedge clk);
      fr[ch] = 0; fp[ch] = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wake(int ch);
    int k;
    @(negedge clk);
    k = cyc;
    run[ch] = 1;
    blank[ch] = 1; lk[ch] = 0; good[ch] = 0;
    push(k, ch, 4, 1, "R9 resync");
    push(k + 1, ch, 4, 0, "R9 resync end");
    push(k, 0, 3, exp_lock(), "R8 wake");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int k;
    // R10 reset state
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      push(cyc, c, 0, 0, "R10");
      push(cyc, c, 1, 0, "R10");
      push(cyc, c, 2, 0, "R10");
      push(cyc, c, 4, 0, "R10");
    end
    push(cyc, 0, 3, 1, "R7 both saving");
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    wake(0);
    cmp(0, 1, 2, "R9 blanked");
    cmp(0, 1, 0, "R3 a");
    cmp(0, 1, 0, "R3 b");
    cmp(0, 1, 0, "R6 third");
    cmp(0, 1, 1, "R1 fr lead");
    cmp(0, 0, 1, "R1 fp lead");
    pol[0] = 0;
    cmp(0, 1, 1, "R2 fr lead");
    cmp(0, 0, 2, "R2 fp lead");
    cmp(0, 1, 0, "R2 R3 coincident");
    pol[0] = 1;
    cmp(0, 1, 3, "R5 big err");
    cmp(0, 1, 0, "R6 run a");
    cmp(0, 0, 1, "R6 run b");
    cmp(0, 0, 2, "R6 break");
    cmp(0, 1, 0, "R6 run c");
    cmp(0, 1, 0, "R6 run d");
    cmp(0, 1, 1, "R6 relock");

    wake(1);
    cmp(1, 0, 1, "R9 blanked ch1");
    cmp(1, 1, 0, "R8 ch1 a");
    cmp(1, 1, 0, "R8 ch1 b");
    cmp(1, 1, 0, "R8 ch1 c");
    cmp(0, 1, 5, "R5 ch0 drop");
    cmp(0, 1, 0, "R8 ch0 a");
    cmp(0, 1, 0, "R8 ch0 b");
    cmp(0, 1, 0, "R8 ch0 c");

    // R7: power save in the middle of a drive pulse
    @(negedge clk);
    k = cyc;
    fr[0] = 1;
    push(k + 1, 0, 2, 1, "R7 pre");
    @(negedge clk);
    fr[0] = 0;
    @(negedge clk);
    run[0] = 0;
    lk[0] = 0; good[0] = 0; blank[0] = 0;
    push(k + 2, 0, 2, 1, "R7 still driving");
    push(k + 2, 0, 3, exp_lock(), "R7 vote");
    push(k + 3, 0, 2, 0, "R7 float");
    push(k + 3, 0, 0, 0, "R7 float up");
    repeat (4) @(negedge clk);
    cmp(0, 1, 2, "R7 ignored");
    cmp(0, 0, 0, "R7 ignored coincident");

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R10 pending items: actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog R10: actual=hang expected=end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule